// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Winner Register

This block gathers up to 64 level-sensitive interrupt inputs and steers each one to a normal interrupt line, a fast interrupt line, or both. Every source owns one 32-bit configuration word. Two bits of that word are route enables; the other bits are plain storage that reads back as written. A source that is asserted and routed is pending. The normal line is the OR of every pending source routed to it, and the fast line works the same way for its own route bit.

Software running on the normal line reads one register to find out which source to serve. That register carries a flag that says whether any normal-routed source is pending and, beside the flag, the number of the lowest-numbered such source. No acknowledge exists. A source stays pending for as long as its input stays high, and it clears itself when the input drops. Both lines and the winner register are registered, so they show a change of input or configuration one clock later.

Top module: `irq_select_unit`

## Requirements
- R1: The configuration word of source n is at byte offset 4*n (word index n, for n below NUM_SRC), and all 32 bits read back exactly as last written.
- R2: Reset clears every configuration word, both interrupt outputs and the winner register.
- R3: irqOut is high exactly when, at the previous clock edge, some source had its input high and bit 5 of its configuration word set.
- R4: fiqOut is high exactly when, at the previous clock edge, some source had its input high and bit 6 of its configuration word set. A source routed only by bit 6 never appears in the winner register.
- R5: The winner register is at byte offset 0x104. Bit 6 is the pending flag, set when irqOut is set. Bits 5:0 hold the winning source number, and read zero when the flag is clear. Bits 31:7 read zero.
- R6: When several normal-routed sources are pending, bits 5:0 of the winner register name the lowest-numbered one.
- R7: Configuration bits other than 5 and 6 have no effect on either output or on the winner register.
- R8: Writes to the winner register are ignored. Reads from offsets that map to no register return zero, and writes to such offsets change no state.
- R9: A pending source clears one clock after its input falls, with no acknowledge access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address; bits 1:0 are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational during a read, zero otherwise |
| srcIn | input | 64 | Level interrupt inputs, one per source |
| irqOut | output | 1 | Normal interrupt line |
| fiqOut | output | 1 | Fast interrupt line |

## Verification
A configuration word stored under the wrong index, or a corrupted route bit, shows up as an output line or a winner number that disagrees with the single source being driven, in the cycle after that source rises. A priority encoder that scans in the wrong direction, or skips an index, shows a wrong winner number when a run of adjacent sources is driven high together. Faulty write decoding shows up on a later readback, either as a changed neighbour word or as an unmapped offset that no longer reads zero. A pending bit that is held too long shows as an output still high one cycle after the input has fallen.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int CFG_W        = 32;
  localparam int SRC_IDX_W    = 6;
  localparam int IRQ_ROUTE    = 5;
  localparam int FIQ_ROUTE    = 6;
  localparam int SEL_PEND_BIT = 6;

  // control -> datapath: one configuration write strobe
  typedef struct packed {
    logic                 wrEn;
    logic [SRC_IDX_W-1:0] idx;
    logic [CFG_W-1:0]     data;
  } cfgStrobe_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int ADDR_W     = 12,
  parameter int SEL_OFFSET = 'h104
) (
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [CFG_W-1:0]     busWdata,
  input  logic [CFG_W-1:0]     cfgRead [NUM_SRC],
  input  logic                 selPend,
  input  logic [SRC_IDX_W-1:0] selNum,
  output cfgStrobe_t           strobe,
  output logic [CFG_W-1:0]     busRdata
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] NUM_WORDS = WORD_W'(NUM_SRC);
  localparam logic [WORD_W-1:0] SEL_WORD  = WORD_W'(SEL_OFFSET >> 2);

  logic [WORD_W-1:0] wordIdx;
  logic              isCfg;
  logic              isSel;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign isCfg   = wordIdx < NUM_WORDS;
  assign isSel   = wordIdx == SEL_WORD;

  always_comb begin
    strobe.wrEn = busSel && busWr && isCfg;
    strobe.idx  = wordIdx[SRC_IDX_W-1:0];
    strobe.data = busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      if (isCfg) begin
        busRdata = cfgRead[wordIdx[SRC_IDX_W-1:0]];
      end else if (isSel) begin
        busRdata[SEL_PEND_BIT]    = selPend;
        busRdata[SRC_IDX_W-1:0]   = selNum;
      end
    end
  end
endmodule

// File: rtl/irq_route_core.sv
module irq_route_core
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic [NUM_SRC-1:0]   srcIn,
  output logic [CFG_W-1:0]     cfgRead [NUM_SRC],
  output logic [NUM_SRC-1:0]   routeIrq,
  output logic [NUM_SRC-1:0]   routeFiq,
  output logic                 irqOut,
  output logic                 fiqOut,
  output logic                 selPend,
  output logic [SRC_IDX_W-1:0] selNum
);
  logic [NUM_SRC-1:0]   pendIrq;
  logic [NUM_SRC-1:0]   pendFiq;
  logic [SRC_IDX_W-1:0] winIdx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [CFG_W-1:0] cfgWord;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgWord <= '0;
      end else if (strobe.wrEn && strobe.idx == SRC_IDX_W'(g)) begin
        cfgWord <= strobe.data;
      end
    end
    assign cfgRead[g]  = cfgWord;
    assign routeIrq[g] = cfgWord[IRQ_ROUTE];
    assign routeFiq[g] = cfgWord[FIQ_ROUTE];
  end

  assign pendIrq = srcIn & routeIrq;
  assign pendFiq = srcIn & routeFiq;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendIrq[i]) winIdx = SRC_IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
      selPend <= 1'b0;
      selNum  <= '0;
    end else begin
      irqOut  <= |pendIrq;
      fiqOut  <= |pendFiq;
      selPend <= |pendIrq;
      selNum  <= winIdx;
    end
  end
endmodule

// File: rtl/irq_select_unit.sv
module irq_select_unit
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int ADDR_W     = 12,
  parameter int SEL_OFFSET = 'h104
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);
  cfgStrobe_t           strobe;
  logic [CFG_W-1:0]     cfgRead [NUM_SRC];
  logic [NUM_SRC-1:0]   routeIrq;
  logic [NUM_SRC-1:0]   routeFiq;
  logic                 selPend;
  logic [SRC_IDX_W-1:0] selNum;

  irq_route_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SEL_OFFSET(SEL_OFFSET)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .cfgRead(cfgRead), .selPend(selPend), .selNum(selNum),
    .strobe(strobe), .busRdata(busRdata)
  );

  irq_route_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcIn(srcIn),
    .cfgRead(cfgRead), .routeIrq(routeIrq), .routeFiq(routeFiq),
    .irqOut(irqOut), .fiqOut(fiqOut), .selPend(selPend), .selNum(selNum)
  );
endmodule

// File: rtl/irq_select_unit_chk.sv
module irq_select_unit_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_SRC-1:0] routeIrq,
  input logic [NUM_SRC-1:0] routeFiq,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               selPend,
  input logic [5:0]         selNum
);
  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|$past(srcIn & routeIrq)));

  a_r4_fiq_follows: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut == (|$past(srcIn & routeFiq)));

  a_r5_flag_matches_line: assert property (@(posedge clk) disable iff (!rstN)
    selPend == irqOut);

  a_r5_idle_number_zero: assert property (@(posedge clk) disable iff (!rstN)
    !selPend |-> selNum == 6'd0);

  a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rstN)
    selPend |-> ((($past(srcIn & routeIrq)) >> selNum) & ONE) != '0);

  a_r6_none_below: assert property (@(posedge clk) disable iff (!rstN)
    selPend |-> ($past(srcIn & routeIrq) & ((ONE << selNum) - ONE)) == '0);
endmodule

bind irq_select_unit irq_select_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .routeIrq(routeIrq), .routeFiq(routeFiq),
  .irqOut(irqOut), .fiqOut(fiqOut), .selPend(selPend), .selNum(selNum)
);

// File: tb/irq_select_unit_bench.sv
module irq_select_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;
  localparam logic [11:0] SEL_ADDR = 12'h104;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] srcIn = '0;
  logic        irqOut;
  logic        fiqOut;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  irq_select_unit u_irq_select_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: got=%0d cycles exp=completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h9E3C_5A00 ^ (32'(i) * 32'h0001_0307)) & ~32'h60;
  endfunction

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: reset state
    busRead(12'h000, rd); chk("R2 cfg0 after reset", rd, 0);
    busRead(12'h0FC, rd); chk("R2 cfg63 after reset", rd, 0);
    busRead(SEL_ADDR, rd); chk("R2 select after reset", rd, 0);
    chk("R2 irq after reset", irqOut, 0);
    chk("R2 fiq after reset", fiqOut, 0);

    // R2: reset mid-run clears a written word and a live output
    busWrite(12'h00C, 32'h20);
    srcIn = 64'h8;
    @(negedge clk);
    chk("R3 irq before reset", irqOut, 1);
    rstN = 1'b0; srcIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busRead(12'h00C, rd); chk("R2 cfg3 cleared by reset", rd, 0);
    chk("R2 irq cleared by reset", irqOut, 0);

    // R1: readback of every word
    for (int i = 0; i < N; i++) busWrite(12'(i * 4), pat(i));
    for (int i = 0; i < N; i++) begin
      busRead(12'(i * 4), rd); chk($sformatf("R1 readback word %0d", i), rd, pat(i));
    end
    for (int i = 0; i < N; i++) busWrite(12'(i * 4), 32'h0);

    // R3 R4 R5 R9: single-source sweep
    for (int i = 0; i < N; i++) begin
      busWrite(12'(i * 4), 32'h20);
      srcIn = N'(1) << i;
      @(negedge clk);
      chk($sformatf("R3 irq src %0d", i), irqOut, 1);
      chk($sformatf("R4 fiq off src %0d", i), fiqOut, 0);
      busRead(SEL_ADDR, rd); chk($sformatf("R5 select src %0d", i), rd, 32'h40 | 32'(i));
      srcIn = '0;
      @(negedge clk);
      chk($sformatf("R9 irq drops src %0d", i), irqOut, 0);
      busRead(SEL_ADDR, rd); chk($sformatf("R9 select idle src %0d", i), rd, 0);
      busWrite(12'(i * 4), 32'h40);
      srcIn = N'(1) << i;
      @(negedge clk);
      chk($sformatf("R4 fiq src %0d", i), fiqOut, 1);
      chk($sformatf("R4 irq off src %0d", i), irqOut, 0);
      busRead(SEL_ADDR, rd); chk($sformatf("R4 fiq-only absent from select %0d", i), rd, 0);
      srcIn = '0;
      busWrite(12'(i * 4), 32'h0);
    end

    // R6: priority, runs of sources from i upward
    for (int i = 0; i < N; i++) busWrite(12'(i * 4), 32'h60);
    for (int i = 0; i < N; i++) begin
      srcIn = {N{1'b1}} << i;
      @(negedge clk);
      busRead(SEL_ADDR, rd); chk($sformatf("R6 lowest of run from %0d", i), rd, 32'h40 | 32'(i));
      chk($sformatf("R6 irq run %0d", i), irqOut, 1);
      chk($sformatf("R6 fiq run %0d", i), fiqOut, 1);
    end
    srcIn = (N'(1) << 50) | (N'(1) << 13);
    @(negedge clk);
    busRead(SEL_ADDR, rd); chk("R6 sparse pair", rd, 32'h40 | 32'd13);

    // R7: non-route bits have no effect
    for (int i = 0; i < N; i++) busWrite(12'(i * 4), 32'hFFFF_FF9F);
    srcIn = '1;
    @(negedge clk);
    chk("R7 irq", irqOut, 0);
    chk("R7 fiq", fiqOut, 0);
    busRead(SEL_ADDR, rd); chk("R7 select", rd, 0);
    busRead(12'h028, rd); chk("R7 readback", rd, 32'hFFFF_FF9F);

    // R8: select writes ignored, unmapped space inert
    busWrite(12'h01C, 32'h20);
    srcIn = N'(1) << 7;
    @(negedge clk);
    busWrite(SEL_ADDR, 32'h0);
    busRead(SEL_ADDR, rd); chk("R8 select write ignored", rd, 32'h47);
    busWrite(12'h100, 32'hFFFF_FFFF);
    busWrite(12'h108, 32'hFFFF_FFFF);
    busWrite(12'hFFC, 32'hFFFF_FFFF);
    busRead(12'h100, rd); chk("R8 unmapped 0x100", rd, 0);
    busRead(12'h108, rd); chk("R8 unmapped 0x108", rd, 0);
    busRead(12'hFFC, rd); chk("R8 unmapped 0xFFC", rd, 0);
    busRead(12'h000, rd); chk("R8 word0 untouched", rd, 32'hFFFF_FF9F);
    busRead(12'h01C, rd); chk("R8 word7 untouched", rd, 32'h20);
    chk("R8 irq kept", irqOut, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule